// File: doc/BRIEF.md
# Supervisory Reset Generator With Debounce

This block drives the system-wide reset line of a chip. Two causes pull the line: the RTC supply is not good, as reported by an external comparator as a digital flag, or a hot-reset push input is held active. The reset line is held from power-up. After every cause has gone away, it stays held for a programmable hold time. The output is modelled as an open-drain enable, where 1 means the pad pulls the line low.

The raw hot-reset pin is active low and may bounce. It is first synchronised to the clock. It then passes through a long filter, which accepts a new level only after that level has been stable for a full filter count. Each accepted press also produces a one-cycle pulse. The voltage code selector uses this pulse to reload its default setting.

The filter length and the hold length are counted in clock cycles. The filter length is a build parameter, and its default corresponds to about 30 ms at 1 MHz. The hold length is a run-time input, nominally 100 ms worth of cycles. Both asynchronous inputs pass through two-stage synchronisers, and all of the cycle counts below assume that default depth.

Top module: `supv_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_out_od` is 1 at once, without waiting for a clock edge. When `por_n` rises with `rtc_good` high and no press, `rst_out_od` falls exactly `hold_cycles`+4 clock edges later.
- R2: While `rtc_good` is 0, `rst_out_od` is 1. After `rtc_good` rises (no press), `rst_out_od` falls exactly `hold_cycles`+2 edges later.
- R3: The hold time follows the `hold_cycles` input, and a value of 0 behaves as a value of 1.
- R4: Any cause that appears during the hold period restarts the count. Release comes `hold_cycles`+2 edges after the last cause ends.
- R5: A low on `hot_rst_n` lasting fewer than FILT_CYCLES cycles is ignored. It gives no `hot_rst_pulse`, and `rst_out_od` stays unchanged.
- R6: A press held for FILT_CYCLES or more cycles gives `hot_rst_pulse` high for exactly one cycle, FILT_CYCLES+2 edges after the pin falls. Releasing the pin gives no pulse.
- R7: An accepted press sets `rst_out_od` one edge after its pulse and keeps it set while the press is held. After the pin returns high, `rst_out_od` falls FILT_CYCLES+`hold_cycles`+2 edges later.
- R8: A release shorter than FILT_CYCLES cycles during a held press is ignored. It gives no second pulse, and the reset is not released.
- R9: The two causes act independently. The reset holds while either cause is active, and a press still gives its pulse when the reset is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rtc_good | input | 1 | RTC supply good flag from the comparator, asynchronous |
| hot_rst_n | input | 1 | Raw hot-reset push input, active low, asynchronous |
| hold_cycles | input | HOLD_W | Hold time after the last cause, in clock cycles (0 acts as 1) |
| rst_out_od | output | 1 | Open-drain enable of the system reset, 1 = pull the line low |
| hot_rst_pulse | output | 1 | One-cycle pulse on each accepted hot-reset press |

## Verification
The release delay is measured edge by edge against the power-on release, a rise of the RTC flag, and the end of a press. This separates the three delay paths, which are the hold plus two synchroniser stages, the hold plus the reset synchroniser, and the hold plus the filter. Two hold values plus zero and one show whether the input is honoured and how zero is clamped. A brief RTC dip inside the hold shows whether the count restarts. Press glitches one cycle short of the filter, on both the press and the release side, separate a filter that counts stable cycles from one that counts total cycles. Overlapping RTC-bad and press periods show that the two causes combine independently and that the pulse does not depend on the current reset state.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;

  // State of the shared hold timer: the reset line is either held or let go.
  typedef enum logic {
    HT_RELEASED = 1'b0,
    HT_HELD     = 1'b1
  } hold_state_e;

  // Asynchronous inputs as seen after the synchroniser, in active-high form.
  typedef struct packed {
    logic rtc_ok;
    logic pressed;
  } cause_bits_t;

  localparam int unsigned CAUSE_BITS = $bits(cause_bits_t);

  // Values the synchronised bits take during reset: RTC not yet good, no press.
  localparam cause_bits_t CAUSE_RST_VAL = '{rtc_ok: 1'b0, pressed: 1'b0};

endpackage

// File: rtl/supv_rst_sync.sv
// Reset synchroniser: asserts asynchronously, releases after STAGES clock edges.
module supv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/supv_bit_sync.sv
// Multi-bit level synchroniser; each bit is independent, reset to RST_VAL.
module supv_bit_sync #(
  parameter int unsigned            WIDTH   = 2,
  parameter int unsigned            STAGES  = 2,
  parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = async_i;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/supv_debounce.sv
// Level filter: a new level is taken only after FILT_CYCLES consecutive
// samples that differ from the current level. Any return to the current
// level restarts the count. A one-cycle pulse marks each accepted rise.
module supv_debounce #(
  parameter int unsigned FILT_CYCLES = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  output logic level_o,
  output logic rise_o
);

  localparam int unsigned CNT_W = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             level_q, level_d;
  logic             rise_q, rise_d;
  logic             differs;
  logic             cnt_done;
  logic             cnt_en;

  always_comb begin
    differs  = (sample_i != level_q);
    cnt_done = (cnt_q == CNT_LAST);
    // The counter register is only written while a change is pending or must be cleared.
    cnt_en   = differs || (cnt_q != '0);
  end

  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    rise_d  = 1'b0;
    if (!differs) begin
      cnt_d = '0;
    end else if (cnt_done) begin
      cnt_d   = '0;
      level_d = sample_i;
      rise_d  = sample_i;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      level_q <= level_d;
      rise_q  <= rise_d;
    end
  end

  assign level_o = level_q;
  assign rise_o  = rise_q;

endmodule

// File: rtl/supv_hold_timer.sv
// Shared hold timer: held while any cause is present, and let go only after
// hold_i consecutive cycles with no cause (0 counts as 1).
module supv_hold_timer
  import supv_reset_pkg::*;
#(
  parameter int unsigned HOLD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cause_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              held_o
);

  hold_state_e       st_q, st_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic [HOLD_W-1:0] last_cnt;
  logic              cnt_en;

  always_comb begin
    last_cnt = (hold_i == '0) ? '0 : (hold_i - HOLD_W'(1));
    cnt_en   = cause_i || (st_q == HT_HELD);
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (cause_i) begin
      st_d  = HT_HELD;
      cnt_d = '0;
    end else if (st_q == HT_HELD) begin
      if (cnt_q >= last_cnt) begin
        st_d  = HT_RELEASED;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + HOLD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HT_HELD;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign held_o = (st_q == HT_HELD);

endmodule

// File: rtl/supv_reset_gen.sv
// Supervisory reset generator: RTC power-good and a filtered hot-reset push
// input share one hold timer that drives an open-drain reset enable.
module supv_reset_gen
  import supv_reset_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 30000,
  parameter int unsigned HOLD_W      = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rtc_good,
  input  logic              hot_rst_n,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              rst_out_od,
  output logic              hot_rst_pulse
);

  logic        rst_n_int;
  cause_bits_t cause_raw;
  cause_bits_t cause_sync;
  logic        rtc_ok_s;
  logic        press_s;
  logic        press_lvl;
  logic        any_cause;
  logic        held;

  supv_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (rst_n_int)
  );

  always_comb begin
    cause_raw.rtc_ok  = rtc_good;
    cause_raw.pressed = ~hot_rst_n;
  end

  supv_bit_sync #(
    .WIDTH   (CAUSE_BITS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CAUSE_RST_VAL)
  ) u_in_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i (cause_raw),
    .sync_o  (cause_sync)
  );

  assign rtc_ok_s = cause_sync.rtc_ok;
  assign press_s  = cause_sync.pressed;

  supv_debounce #(
    .FILT_CYCLES (FILT_CYCLES)
  ) u_debounce (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sample_i (press_s),
    .level_o  (press_lvl),
    .rise_o   (hot_rst_pulse)
  );

  assign any_cause = (~rtc_ok_s) | press_lvl;

  supv_hold_timer #(
    .HOLD_W (HOLD_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cause_i (any_cause),
    .hold_i  (hold_cycles),
    .held_o  (held)
  );

  // The line is pulled while the power-on reset is low, without a clock edge.
  assign rst_out_od = held | ~por_n;

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk (
  input logic clk,
  input logic rst_n,
  input logic rtc_ok_s,
  input logic press_s,
  input logic press_lvl,
  input logic rst_out_od,
  input logic hot_rst_pulse
);

  AST_RTC_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_ok_s |=> rst_out_od); // R2

  AST_RELEASE_NEEDS_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_od) |-> ($past(rtc_ok_s) && !$past(press_lvl))); // R4

  AST_LEVEL_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(press_lvl) |-> (press_lvl == $past(press_s))); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hot_rst_pulse |=> !hot_rst_pulse); // R6

  AST_PULSE_ON_PRESS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    hot_rst_pulse |-> (press_lvl && !$past(press_lvl))); // R6

  AST_PULSE_PULLS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    hot_rst_pulse |=> rst_out_od); // R7

  AST_HELD_PRESS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    press_lvl |=> rst_out_od); // R9

endmodule

bind supv_reset_gen supv_reset_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n_int),
  .rtc_ok_s      (rtc_ok_s),
  .press_s       (press_s),
  .press_lvl     (press_lvl),
  .rst_out_od    (rst_out_od),
  .hot_rst_pulse (hot_rst_pulse)
);

// File: tb/sim_supv_reset_gen.sv
module sim_supv_reset_gen;

  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 8;
  localparam int HW         = 8;

  logic          clk;
  logic          por_n;
  logic          rtc_good;
  logic          hot_rst_n;
  logic [HW-1:0] hold_cycles;
  logic          rst_out_od;
  logic          hot_rst_pulse;

  int n_checks;
  int n_fail;

  supv_reset_gen #(
    .FILT_CYCLES (FILT),
    .HOLD_W      (HW),
    .SYNC_STAGES (2)
  ) u0 (
    .clk           (clk),
    .por_n         (por_n),
    .rtc_good      (rtc_good),
    .hot_rst_n     (hot_rst_n),
    .hold_cycles   (hold_cycles),
    .rst_out_od    (rst_out_od),
    .hot_rst_pulse (hot_rst_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One posedge, then settle at the following negedge (sample/drive point).
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (hot_rst_pulse) pulses++;
    end
  endtask

  task automatic wait_release(input int limit, output int edges, output int pulses);
    edges  = 0;
    pulses = 0;
    while (rst_out_od && edges < limit) begin
      step();
      edges++;
      if (hot_rst_pulse) pulses++;
    end
  endtask

  task automatic wait_pulse(input int limit, output int edges);
    edges = 0;
    do begin
      step();
      edges++;
    end while (!hot_rst_pulse && edges < limit);
  endtask

  task automatic t_power_on();
    int e, p;
    hold_cycles = 8'd6;
    steps(3, p);
    check(rst_out_od == 1'b1, "R1 held during power-on reset", rst_out_od, 1);
    check(p == 0, "R1 no pulse during reset", p, 0);
    por_n = 1'b1;
    wait_release(100, e, p);
    check(e == 6 + 4, "R1 release delay after por_n", e, 10);
    por_n = 1'b0;
    #1;
    check(rst_out_od == 1'b1, "R1 asynchronous assertion", rst_out_od, 1);
    steps(2, p);
    por_n = 1'b1;
    wait_release(100, e, p);
    check(e == 6 + 4, "R1 release delay after second reset", e, 10);
  endtask

  task automatic t_rtc_hold();
    int e, p;
    hold_cycles = 8'd6;
    rtc_good = 1'b0;
    steps(3, p);
    check(rst_out_od == 1'b1, "R2 held while rtc bad", rst_out_od, 1);
    steps(20, p);
    check(rst_out_od == 1'b1, "R2 still held after long rtc bad", rst_out_od, 1);
    rtc_good = 1'b1;
    wait_release(100, e, p);
    check(e == 6 + 2, "R2 release delay after rtc good", e, 8);
  endtask

  task automatic t_hold_prog();
    int e, p;
    hold_cycles = 8'd20;
    rtc_good = 1'b0;
    steps(3, p);
    rtc_good = 1'b1;
    wait_release(100, e, p);
    check(e == 22, "R3 hold of 20 cycles", e, 22);
    hold_cycles = 8'd1;
    rtc_good = 1'b0;
    steps(3, p);
    rtc_good = 1'b1;
    wait_release(100, e, p);
    check(e == 3, "R3 hold of 1 cycle", e, 3);
    hold_cycles = 8'd0;
    rtc_good = 1'b0;
    steps(3, p);
    rtc_good = 1'b1;
    wait_release(100, e, p);
    check(e == 3, "R3 hold of 0 acts as 1", e, 3);
  endtask

  task automatic t_hold_restart();
    int e, p;
    hold_cycles = 8'd10;
    rtc_good = 1'b0;
    steps(4, p);
    rtc_good = 1'b1;
    steps(5, p);
    check(rst_out_od == 1'b1, "R4 still held mid hold", rst_out_od, 1);
    rtc_good = 1'b0;
    step();
    rtc_good = 1'b1;
    wait_release(100, e, p);
    check(e == 12, "R4 hold restarts after dip", e, 12);
  endtask

  task automatic t_press_glitch();
    int p;
    hold_cycles = 8'd4;
    hot_rst_n = 1'b0;
    steps(FILT - 1, p);
    hot_rst_n = 1'b1;
    begin
      int p2;
      steps(3 * FILT, p2);
      p += p2;
    end
    check(p == 0, "R5 short press gives no pulse", p, 0);
    check(rst_out_od == 1'b0, "R5 short press leaves reset released", rst_out_od, 0);
  endtask

  task automatic t_press();
    int e, p;
    hold_cycles = 8'd4;
    hot_rst_n = 1'b0;
    wait_pulse(100, e);
    check(e == FILT + 2, "R6 pulse delay after press", e, FILT + 2);
    check(rst_out_od == 1'b0, "R7 reset not yet pulled at pulse", rst_out_od, 0);
    step();
    check(hot_rst_pulse == 1'b0, "R6 pulse is one cycle wide", hot_rst_pulse, 0);
    check(rst_out_od == 1'b1, "R7 reset pulled one edge after pulse", rst_out_od, 1);
    steps(20, p);
    check(p == 0, "R6 no extra pulse while held", p, 0);
    check(rst_out_od == 1'b1, "R7 reset held during press", rst_out_od, 1);
    hot_rst_n = 1'b1;
    wait_release(100, e, p);
    check(e == FILT + 4 + 2, "R7 release delay after press ends", e, FILT + 6);
    check(p == 0, "R6 no pulse on release", p, 0);
  endtask

  task automatic t_release_glitch();
    int e, p, p2;
    hold_cycles = 8'd4;
    hot_rst_n = 1'b0;
    wait_pulse(100, e);
    steps(3, p);
    hot_rst_n = 1'b1;
    steps(FILT - 1, p);
    hot_rst_n = 1'b0;
    steps(2 * FILT, p2);
    check(p + p2 == 0, "R8 short release gives no second pulse", p + p2, 0);
    check(rst_out_od == 1'b1, "R8 short release keeps reset", rst_out_od, 1);
    hot_rst_n = 1'b1;
    wait_release(100, e, p);
    check(e == FILT + 6, "R8 release delay after real release", e, FILT + 6);
  endtask

  task automatic t_both_causes();
    int e, p;
    hold_cycles = 8'd5;
    rtc_good = 1'b0;
    steps(4, p);
    hot_rst_n = 1'b0;
    wait_pulse(100, e);
    check(e == FILT + 2, "R9 pulse while reset already held", e, FILT + 2);
    rtc_good = 1'b1;
    steps(30, p);
    check(rst_out_od == 1'b1, "R9 press holds after rtc recovers", rst_out_od, 1);
    rtc_good = 1'b0;
    hot_rst_n = 1'b1;
    steps(30, p);
    check(rst_out_od == 1'b1, "R9 rtc bad holds after press ends", rst_out_od, 1);
    rtc_good = 1'b1;
    wait_release(100, e, p);
    check(e == 7, "R9 release once both causes gone", e, 7);
  endtask

  initial begin
    n_checks    = 0;
    n_fail      = 0;
    por_n       = 1'b0;
    rtc_good    = 1'b1;
    hot_rst_n   = 1'b1;
    hold_cycles = '0;
    @(negedge clk);
    t_power_on();
    t_rtc_hold();
    t_hold_prog();
    t_hold_restart();
    t_press_glitch();
    t_press();
    t_release_glitch();
    t_both_causes();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule